// File: doc/BRIEF.md
# Master-ID peripheral access filter

This block sits between the bus fabric and a row of peripheral slots. It decides, in the same cycle, whether a bus master may reach the slot it addresses. The address space is split into 1 KB peripheral frames, and each frame is split into four 256-byte quadrants. Every implemented quadrant holds a 16-bit permission mask. Mask bit n admits the master whose 4-bit ID is n.

How each frame uses its quadrants is fixed when the block is elaborated. Each frame has a 2-bit code in the `FRAME_MODE` parameter, held in bits `2f+1:2f` for frame f. The four codes are:

- 0: four separate single-quadrant slaves.
- 1: two slaves, one spanning quadrants 0–1 and one spanning quadrants 2–3.
- 2: one slave across the whole frame.
- 3: one slave spanning quadrants 0–1, plus single slaves in quadrants 2 and 3.

A multi-quadrant slave is guarded by the mask of its lowest quadrant. Masks that are not needed are not built. They read as zero and drop writes.

Software programs the masks through a plain 32-bit register port with a privilege flag. Frame f owns two words, at byte offsets 8f and 8f+4. The lower word holds quadrant 0 in bits 15:0 and quadrant 1 in bits 31:16. The upper word holds quadrants 2 and 3 in the same layout. The port carries only the word-address bits, so `cfg_addr` spans bits `REG_AW-1:2` of the byte offset. Reads are combinational from `cfg_addr`, and writes take effect at the clock edge.

The check side has no back-pressure. A request is taken whenever `req_valid` is high, and the answer on `grant`/`deny` is combinational in the same cycle. No ready signal exists, because the filter never stalls. Only address bits at and above bit 8 are carried: bits 9:8 select the quadrant and the bits above them select the frame.

Top module: `pguard_top`

## Requirements
- R1: For a valid request, `grant` is 1 exactly when bit `req_mid` of the governing mask is 1, and `deny` is 1 exactly when that bit is 0. For example, with mask 0xAAAA master 3 is granted and master 2 is denied.
- R2: After reset every implemented mask holds 0xFFFF, so all masters are granted.
- R3: A register write with `cfg_priv` low leaves every mask unchanged.
- R4: A write with `cfg_priv` high to byte offset 8f updates quadrant 0 of frame f from `cfg_wdata[15:0]` and quadrant 1 from `cfg_wdata[31:16]`. A write to 8f+4 updates quadrants 2 and 3 the same way. A read of the same offset returns the stored word.
- R5: Bits of unimplemented quadrants read as 0 and are not changed by writes.
- R6: In a frame with mode 2, only the quadrant 0 mask exists, and it governs requests to all four quadrants.
- R7: In a frame with mode 1, only the quadrant 0 and quadrant 2 masks exist. The quadrant 0 mask governs quadrants 0–1, and the quadrant 2 mask governs quadrants 2–3.
- R8: In a frame with mode 0, all four masks exist, and each quadrant is governed by its own mask.
- R9: In a frame with mode 3, quadrants 0–1 are governed by the quadrant 0 mask, and quadrants 2 and 3 are each governed by their own mask. The quadrant 1 mask is absent.
- R10: With `req_valid` low, `grant` and `deny` are both 0. `grant` and `deny` are never 1 together.
- R11: A valid request to a frame index at or above `NFRAMES` is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_priv | input | 1 | Write comes from a privileged-mode access |
| cfg_addr | input | REG_AW-2 | Register byte offset, bits REG_AW-1:2 |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| req_valid | input | 1 | Access request valid |
| req_addr | input | ADDR_W-8 | Access address, bits ADDR_W-1:8 |
| req_mid | input | 4 | Master ID of the request |
| grant | output | 1 | Request permitted |
| deny | output | 1 | Request blocked |

## Verification
The bound checker checks the following on every cycle:
- `grant` and `deny` are never high together, and both are quiet when no request is valid.
- Requests to out-of-range frames are denied.
- Unimplemented mask bits always read as zero.
- An unprivileged write leaves the addressed word unchanged.
- A privileged write reads back as its data masked to the implemented quadrants.

Only the bench scenarios can show two things. The first is that the right mask governs each quadrant under each of the four frame modes. The second is that the mask bit chosen by the master ID decides the outcome, for example the odd-ID mask and the single-master mask.

// File: rtl/pguard_pkg.sv
package pguard_pkg;

  localparam int MID_W   = 4;
  localparam int MASK_W  = 1 << MID_W;
  localparam int QUADS   = 4;

  typedef enum logic [1:0] {
    USE_SPLIT4  = 2'd0,
    USE_PAIRS   = 2'd1,
    USE_WHOLE   = 2'd2,
    USE_LOWPAIR = 2'd3
  } quad_use_e;

  typedef logic [QUADS-1:0][MASK_W-1:0] frame_masks_t;

  // Whether a quadrant keeps its own mask under a frame usage code
  function automatic logic quad_impl(logic [1:0] mode, logic [1:0] q);
    case (mode)
      USE_PAIRS:   return !q[0];
      USE_WHOLE:   return q == 2'd0;
      USE_LOWPAIR: return q != 2'd1;
      default:     return 1'b1;
    endcase
  endfunction

  // Quadrant whose mask decides an access to quadrant q
  function automatic logic [1:0] gov_quad(logic [1:0] mode, logic [1:0] q);
    case (mode)
      USE_PAIRS:   return {q[1], 1'b0};
      USE_WHOLE:   return 2'd0;
      USE_LOWPAIR: return q[1] ? q : 2'd0;
      default:     return q;
    endcase
  endfunction

  // Bits of a register word backed by storage
  function automatic logic [31:0] word_impl(logic [1:0] mode, logic half);
    return {{MASK_W{quad_impl(mode, {half, 1'b1})}},
            {MASK_W{quad_impl(mode, {half, 1'b0})}}};
  endfunction

endpackage

// File: rtl/pguard_regbank.sv
module pguard_regbank
  import pguard_pkg::*;
#(
  parameter int NFRAMES = 32,
  parameter logic [2*NFRAMES-1:0] FRAME_MODE = '0,
  localparam int FRAME_IW = $clog2(NFRAMES),
  localparam int REG_AW = FRAME_IW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_priv,
  input  logic [REG_AW-1:2] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output frame_masks_t      masks [NFRAMES]
);

  logic [FRAME_IW-1:0] sel_frame;
  logic                sel_half;
  logic                wr_go;

  assign sel_frame = cfg_addr[REG_AW-1:3];
  assign sel_half  = cfg_addr[2];
  assign wr_go     = cfg_we & cfg_priv;

  for (genvar f = 0; f < NFRAMES; f++) begin : g_frame
    localparam logic [1:0] MODE = FRAME_MODE[2*f +: 2];
    for (genvar q = 0; q < QUADS; q++) begin : g_quad
      localparam logic [1:0] QI = 2'(q);
      if (quad_impl(MODE, QI)) begin : g_live
        logic [MASK_W-1:0] mreg;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            mreg <= '1;
          end else if (wr_go && sel_frame == FRAME_IW'(f) && sel_half == QI[1]) begin
            mreg <= QI[0] ? cfg_wdata[31:16] : cfg_wdata[15:0];
          end
        end
        assign masks[f][q] = mreg;
      end else begin : g_none
        assign masks[f][q] = '0;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (32'(sel_frame) < NFRAMES) begin
      cfg_rdata = {masks[sel_frame][{sel_half, 1'b1}],
                   masks[sel_frame][{sel_half, 1'b0}]};
    end
  end

endmodule

// File: rtl/pguard_decide.sv
module pguard_decide
  import pguard_pkg::*;
#(
  parameter int NFRAMES = 32,
  parameter logic [2*NFRAMES-1:0] FRAME_MODE = '0,
  parameter int ADDR_W = 16,
  localparam int FRAME_IW = $clog2(NFRAMES),
  localparam int FIDX_W = ADDR_W - 10
) (
  input  frame_masks_t       masks [NFRAMES],
  input  logic               req_valid,
  input  logic [ADDR_W-1:8]  req_addr,
  input  logic [MID_W-1:0]   req_mid,
  output logic               grant,
  output logic               deny
);

  logic [FIDX_W-1:0]   fidx;
  logic [FRAME_IW-1:0] fsel;
  logic                in_range;
  logic [1:0]          mode;
  logic [1:0]          gq;
  logic                allowed;

  assign fidx     = req_addr[ADDR_W-1:10];
  assign fsel     = FRAME_IW'(fidx);
  assign in_range = 32'(fidx) < NFRAMES;
  assign mode     = FRAME_MODE[{fsel, 1'b0} +: 2];
  assign gq       = gov_quad(mode, req_addr[9:8]);
  assign allowed  = in_range && masks[fsel][gq][req_mid];

  assign grant = req_valid & allowed;
  assign deny  = req_valid & ~allowed;

endmodule

// File: rtl/pguard_top.sv
module pguard_top
  import pguard_pkg::*;
#(
  parameter int NFRAMES = 32,
  // frame 0 whole, frame 1 pairs, frame 2 low pair + singles, rest split
  parameter logic [2*NFRAMES-1:0] FRAME_MODE = (2*NFRAMES)'(6'b11_01_10),
  parameter int ADDR_W = 16,
  localparam int REG_AW = $clog2(NFRAMES) + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_priv,
  input  logic [REG_AW-1:2] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:8] req_addr,
  input  logic [MID_W-1:0]  req_mid,
  output logic              grant,
  output logic              deny
);

  frame_masks_t masks [NFRAMES];

  pguard_regbank #(
    .NFRAMES    (NFRAMES),
    .FRAME_MODE (FRAME_MODE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_priv  (cfg_priv),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .masks     (masks)
  );

  pguard_decide #(
    .NFRAMES    (NFRAMES),
    .FRAME_MODE (FRAME_MODE),
    .ADDR_W     (ADDR_W)
  ) u_decide (
    .masks     (masks),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_mid   (req_mid),
    .grant     (grant),
    .deny      (deny)
  );

endmodule

// File: rtl/pguard_sva.sv
module pguard_sva
  import pguard_pkg::*;
#(
  parameter int NFRAMES = 32,
  parameter logic [2*NFRAMES-1:0] FRAME_MODE = '0,
  parameter int ADDR_W = 16,
  localparam int FRAME_IW = $clog2(NFRAMES),
  localparam int REG_AW = FRAME_IW + 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_priv,
  input logic [REG_AW-1:2] cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic              req_valid,
  input logic [ADDR_W-1:10] req_frame,
  input logic              grant,
  input logic              deny
);

  logic [FRAME_IW-1:0] cfg_frame;
  logic                cfg_in_range;
  logic [1:0]          cfg_mode;
  logic [31:0]         impl_word;
  logic                req_out;

  assign cfg_frame    = cfg_addr[REG_AW-1:3];
  assign cfg_in_range = 32'(cfg_frame) < NFRAMES;
  assign cfg_mode     = FRAME_MODE[{cfg_frame, 1'b0} +: 2];
  assign impl_word    = cfg_in_range ? word_impl(cfg_mode, cfg_addr[2]) : 32'd0;
  assign req_out      = 32'(req_frame) >= NFRAMES;

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!grant && !deny));

  assert_out_of_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_out) |-> deny);

  assert_unimpl_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~impl_word) == 32'd0);

  assert_unpriv_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_we && !cfg_priv) && $stable(cfg_addr)) |-> $stable(cfg_rdata));

  assert_priv_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_we && cfg_priv) && $stable(cfg_addr) && cfg_in_range)
      |-> (cfg_rdata == ($past(cfg_wdata) & impl_word)));

endmodule

bind pguard_top pguard_sva #(
  .NFRAMES    (NFRAMES),
  .FRAME_MODE (FRAME_MODE),
  .ADDR_W     (ADDR_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_priv  (cfg_priv),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .req_valid (req_valid),
  .req_frame (req_addr[ADDR_W-1:10]),
  .grant     (grant),
  .deny      (deny)
);

// File: tb/tb_pguard_top.sv
module tb_pguard_top;

  localparam int NFRAMES = 32;
  localparam int ADDR_W  = 16;
  localparam int REG_AW  = $clog2(NFRAMES) + 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic              cfg_priv = 1'b0;
  logic [REG_AW-1:2] cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:8] req_addr = '0;
  logic [3:0]        req_mid = '0;
  logic              grant;
  logic              deny;

  pguard_top #(.NFRAMES(NFRAMES), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_mid(req_mid),
    .grant(grant), .deny(deny)
  );

  always #4 clk = ~clk;

  typedef struct {
    bit          is_read;
    logic        exp_g;
    logic        exp_d;
    logic [31:0] exp_r;
    string       tag;
  } item_t;

  item_t sbq[$];
  item_t cur;
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  // monitor: compares outputs two ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      cur = sbq.pop_front();
      checks++;
      if (cur.is_read) begin
        if (cfg_rdata !== cur.exp_r) begin
          fails++;
          $display("FAIL %s: rdata=%h expected %h", cur.tag, cfg_rdata, cur.exp_r);
        end
      end else if (grant !== cur.exp_g || deny !== cur.exp_d) begin
        fails++;
        $display("FAIL %s: grant=%b deny=%b expected grant=%b deny=%b",
                 cur.tag, grant, deny, cur.exp_g, cur.exp_d);
      end
    end
  end

  task automatic wr(input logic [7:0] off, input logic [31:0] data, input logic priv);
    @(negedge clk);
    cfg_addr  = off[REG_AW-1:2];
    cfg_wdata = data;
    cfg_priv  = priv;
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
    cfg_priv  = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    cfg_addr   = off[REG_AW-1:2];
    it.is_read = 1'b1;
    it.exp_g   = 1'b0;
    it.exp_d   = 1'b0;
    it.exp_r   = exp;
    it.tag     = tag;
    sbq.push_back(it);
  endtask

  task automatic acc(input logic [15:0] addr, input logic [3:0] mid, input logic v,
                     input logic g, input string tag);
    item_t it;
    @(negedge clk);
    req_addr   = addr[ADDR_W-1:8];
    req_mid    = mid;
    req_valid  = v;
    it.is_read = 1'b0;
    it.exp_g   = v & g;
    it.exp_d   = v & ~g;
    it.exp_r   = '0;
    it.tag     = tag;
    sbq.push_back(it);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 and R5: reset contents
    rd(8'h18, 32'hFFFF_FFFF, "R2 split frame3 lo");
    rd(8'h1C, 32'hFFFF_FFFF, "R2 split frame3 hi");
    rd(8'h00, 32'h0000_FFFF, "R5 whole frame0 lo");
    rd(8'h04, 32'h0000_0000, "R5 whole frame0 hi");
    rd(8'h08, 32'h0000_FFFF, "R5 pairs frame1 lo");
    rd(8'h0C, 32'h0000_FFFF, "R5 pairs frame1 hi");
    rd(8'h10, 32'h0000_FFFF, "R5 lowpair frame2 lo");
    rd(8'h14, 32'hFFFF_FFFF, "R2 lowpair frame2 hi");
    acc(16'h0D00, 4'd9, 1'b1, 1'b1, "R2 reset grant");

    // R3: unprivileged write ignored
    wr(8'h18, 32'h0000_0000, 1'b0);
    rd(8'h18, 32'hFFFF_FFFF, "R3 unpriv write");
    acc(16'h0C00, 4'd6, 1'b1, 1'b1, "R3 grant kept");

    // R4, R1, R8: split frame 3
    wr(8'h18, 32'h0001_AAAA, 1'b1);
    rd(8'h18, 32'h0001_AAAA, "R4 readback lo");
    acc(16'h0C00, 4'd3, 1'b1, 1'b1, "R1 odd mid granted");
    acc(16'h0C00, 4'd2, 1'b1, 1'b0, "R1 even mid denied");
    acc(16'h0D00, 4'd0, 1'b1, 1'b1, "R1 only mid0 granted");
    acc(16'h0D00, 4'd1, 1'b1, 1'b0, "R1 mid1 denied");
    acc(16'h0E00, 4'd7, 1'b1, 1'b1, "R8 q2 own mask");
    wr(8'h1C, 32'h8000_0000, 1'b1);
    rd(8'h1C, 32'h8000_0000, "R4 readback hi");
    acc(16'h0E00, 4'd5, 1'b1, 1'b0, "R8 q2 denies");
    acc(16'h0F00, 4'd15, 1'b1, 1'b1, "R8 q3 mid15");
    acc(16'h0F00, 4'd14, 1'b1, 1'b0, "R8 q3 mid14");

    // R6: whole frame 0
    wr(8'h00, 32'hFFFF_0010, 1'b1);
    rd(8'h00, 32'h0000_0010, "R5 whole upper dropped");
    wr(8'h04, 32'hFFFF_FFFF, 1'b1);
    rd(8'h04, 32'h0000_0000, "R5 whole hi ignored");
    acc(16'h0000, 4'd4, 1'b1, 1'b1, "R6 q0 mid4");
    acc(16'h0300, 4'd4, 1'b1, 1'b1, "R6 q3 via q0");
    acc(16'h0200, 4'd5, 1'b1, 1'b0, "R6 q2 via q0 deny");

    // R7: pairs frame 1
    wr(8'h08, 32'h1234_0002, 1'b1);
    rd(8'h08, 32'h0000_0002, "R7 pair lo read");
    wr(8'h0C, 32'hFFFF_0004, 1'b1);
    rd(8'h0C, 32'h0000_0004, "R7 pair hi read");
    acc(16'h0500, 4'd1, 1'b1, 1'b1, "R7 q1 via q0");
    acc(16'h0500, 4'd2, 1'b1, 1'b0, "R7 q1 deny");
    acc(16'h0700, 4'd2, 1'b1, 1'b1, "R7 q3 via q2");
    acc(16'h0700, 4'd1, 1'b1, 1'b0, "R7 q3 deny");

    // R9: low pair plus singles frame 2
    wr(8'h10, 32'hFFFF_0008, 1'b1);
    rd(8'h10, 32'h0000_0008, "R9 lo read");
    wr(8'h14, 32'h0020_0010, 1'b1);
    rd(8'h14, 32'h0020_0010, "R9 hi read");
    acc(16'h0900, 4'd3, 1'b1, 1'b1, "R9 q1 via q0");
    acc(16'h0A00, 4'd4, 1'b1, 1'b1, "R9 q2 own");
    acc(16'h0A00, 4'd5, 1'b1, 1'b0, "R9 q2 deny");
    acc(16'h0B00, 4'd5, 1'b1, 1'b1, "R9 q3 own");
    acc(16'h0B00, 4'd4, 1'b1, 1'b0, "R9 q3 deny");

    // R10: no valid, no answer
    acc(16'h0B00, 4'd4, 1'b0, 1'b0, "R10 idle on denied slot");
    acc(16'h0B00, 4'd5, 1'b0, 1'b0, "R10 idle on granted slot");

    // R11: frame beyond range
    acc(16'h8000, 4'd0, 1'b1, 1'b0, "R11 frame 32 denied");
    acc(16'hFF00, 4'd15, 1'b1, 1'b0, "R11 frame 63 denied");

    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule